// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Age-Counter Replacement

This block is the tag side of one bank of a set-associative cache. Each way of each set keeps a valid flag, a dirty flag, a tag and a small age counter. A request carries a set index, a tag and a read/write flag. The block compares the tag against every way of the addressed set and updates the age counters. It picks a victim way and decides what the surrounding cache has to do next: acknowledge the request, allocate a miss-holding entry for a refill, write back a dirty victim, or forward a write to memory. Data arrays and memory traffic stay outside the block. It emits only these control decisions and the line addresses they need.

A separate fill port installs a line into a chosen way once the refill data has arrived. A parameter selects the write policy at elaboration: write-back, where write hits mark lines dirty, or write-through, where every write goes to memory. All results are registered. A small controller moves between two named states. In `ST_IDLE` no result is presented. In `ST_REPORT` the result of the request accepted on the previous edge is presented. The transition taken on each edge is "request seen", which leads to `ST_REPORT`, or "no request", which leads to `ST_IDLE`.

Top module: `setassoc_lookup`

## Requirements
- R1: After reset every way of every set is invalid, with clear dirty flags and zero ages, and `rsp_valid` is low.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. All other `rsp_*` flags are low when no result is presented.
- R3: A lookup hits when some valid way of the addressed set holds the request tag. `rsp_hit_way` reports the lowest such way, or 0 on a miss. Every matching way has its age reset to zero.
- R4: On a lookup, every valid way that does not match increments its age. The age saturates at 2^AGE_W-1 and does not wrap. Invalid ways keep their age.
- R5: When all ways are valid, the victim is the way with the largest age after the update, and ties go to the lowest index.
- R6: When any way is invalid, the victim is the highest-indexed invalid way.
- R7: In write-back mode, a write hit sets the dirty flag of the hit way.
- R8: In write-back mode, a miss with no invalid way raises `rsp_wb_req` exactly when the victim is dirty. `rsp_wb_addr` is then {victim tag, set index, BANK_IDX}, with the bank index in the low BANK_W bits.
- R9: In write-through mode, every write raises `rsp_wt_req` with `rsp_wt_addr` = {request tag, set index, BANK_IDX}. A write hit sets no dirty flag, and write-back is never requested.
- R10: In write-through mode, a write miss is acknowledged (`rsp_ack`) without allocation.
- R11: A read miss, or a write miss in write-back mode, raises `rsp_alloc` and not `rsp_ack`. Every hit raises `rsp_ack` and not `rsp_alloc`.
- R12: A fill makes the selected way valid and clean, loads its tag and zeroes its age. When a fill and a lookup touch the same way on one edge, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | Request is a write |
| req_set | input | SET_W | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| fill_valid | input | 1 | Install a line |
| fill_set | input | SET_W | Set of the line to install |
| fill_way | input | WAY_W | Way to install into |
| fill_tag | input | TAG_W | Tag to install |
| rsp_valid | output | 1 | Result presented this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | WAY_W | Hit way (0 on miss) |
| rsp_victim_way | output | WAY_W | Chosen replacement way |
| rsp_ack | output | 1 | Request may be acknowledged now |
| rsp_alloc | output | 1 | Allocate a miss-holding entry for the victim |
| rsp_wb_req | output | 1 | Write back the dirty victim |
| rsp_wb_addr | output | TAG_W+SET_W+BANK_W | Line address of the victim |
| rsp_wt_req | output | 1 | Forward the write to memory |
| rsp_wt_addr | output | TAG_W+SET_W+BANK_W | Line address of the forwarded write |

## Verification
Some properties hold on every cycle, and the bound checker checks those. They are the one-cycle result timing, the mutual exclusion of acknowledge and allocation, the rule that a hit never asks for allocation or write-back, the acknowledge rule on misses under each policy, and the absence of write-back requests in write-through mode. Other behaviour depends on stored history, and only the bench's scenarios against a reference model can show it. This covers age saturation, tie-breaking among equal ages, dirty flags set by earlier write hits that surface as write-backs many lookups later, and a fill that collides with a lookup on the same way.

// File: rtl/sal_pkg.sv
package sal_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } sal_state_e;
endpackage

// File: rtl/sal_set_store.sv
module sal_set_store #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 8,
    parameter int AGE_W    = 3,
    parameter int SET_W    = $clog2(NUM_SETS),
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [SET_W-1:0]                     rd_set,
    output logic [NUM_WAYS-1:0]                  rd_valid,
    output logic [NUM_WAYS-1:0]                  rd_dirty,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]       rd_age,
    input  logic                                 upd_en,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]       upd_age,
    input  logic                                 upd_dirty,
    input  logic [WAY_W-1:0]                     upd_dirty_way,
    input  logic                                 fill_en,
    input  logic [SET_W-1:0]                     fill_set,
    input  logic [WAY_W-1:0]                     fill_way,
    input  logic [TAG_W-1:0]                     fill_tag
);
    logic [NUM_SETS-1:0][NUM_WAYS-1:0]             valid_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0]             dirty_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0]  age_q;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            logic fill_hit;
            logic upd_hit;
            assign fill_hit = fill_en && (fill_set == SET_W'(s)) && (fill_way == WAY_W'(w));
            assign upd_hit  = upd_en && (rd_set == SET_W'(s));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    age_q[s][w]   <= '0;
                end else if (fill_hit) begin
                    valid_q[s][w] <= 1'b1;
                    dirty_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= fill_tag;
                    age_q[s][w]   <= '0;
                end else if (upd_hit) begin
                    age_q[s][w] <= upd_age[w];
                    if (upd_dirty && (upd_dirty_way == WAY_W'(w))) begin
                        dirty_q[s][w] <= 1'b1;
                    end
                end
            end
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_age   = age_q[rd_set];
endmodule

// File: rtl/sal_way_eval.sv
module sal_way_eval #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 8,
    parameter int AGE_W    = 3,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]            rd_valid,
    input  logic [NUM_WAYS-1:0]            rd_dirty,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0] rd_age,
    input  logic [TAG_W-1:0]               req_tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way,
    output logic [NUM_WAYS-1:0][AGE_W-1:0] new_age,
    output logic [WAY_W-1:0]               victim_way,
    output logic                           any_invalid,
    output logic                           victim_dirty,
    output logic [TAG_W-1:0]               victim_tag
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = rd_valid[w] && (rd_tag[w] == req_tag);
        always_comb begin
            if (match[w]) begin
                new_age[w] = '0;
            end else if (rd_valid[w]) begin
                new_age[w] = (rd_age[w] == AGE_MAX) ? AGE_MAX : rd_age[w] + 1'b1;
            end else begin
                new_age[w] = rd_age[w];
            end
        end
    end

    assign hit         = |match;
    assign any_invalid = ~&rd_valid;

    always_comb begin
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        logic [AGE_W-1:0] best;
        victim_way = '0;
        best       = new_age[0];
        for (int w = 1; w < NUM_WAYS; w++) begin
            if (new_age[w] > best) begin
                best       = new_age[w];
                victim_way = WAY_W'(w);
            end
        end
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!rd_valid[w]) victim_way = WAY_W'(w);
        end
    end

    assign victim_dirty = rd_dirty[victim_way];
    assign victim_tag   = rd_tag[victim_way];
endmodule

// File: rtl/sal_ctrl.sv
module sal_ctrl
    import sal_pkg::*;
#(
    parameter int TAG_W         = 8,
    parameter int SET_W         = 3,
    parameter int WAY_W         = 2,
    parameter int BANK_W        = 2,
    parameter int BANK_IDX      = 0,
    parameter bit WRITE_THROUGH = 1'b0,
    parameter int ADDR_W        = TAG_W + SET_W + BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SET_W-1:0]   req_set,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic               hit,
    input  logic [WAY_W-1:0]   hit_way,
    input  logic [WAY_W-1:0]   victim_way,
    input  logic               any_invalid,
    input  logic               victim_dirty,
    input  logic [TAG_W-1:0]   victim_tag,
    output logic               upd_dirty,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WAY_W-1:0]   rsp_hit_way,
    output logic [WAY_W-1:0]   rsp_victim_way,
    output logic               rsp_ack,
    output logic               rsp_alloc,
    output logic               rsp_wb_req,
    output logic [ADDR_W-1:0]  rsp_wb_addr,
    output logic               rsp_wt_req,
    output logic [ADDR_W-1:0]  rsp_wt_addr
);
    localparam logic [BANK_W-1:0] BANK_BITS = BANK_W'(BANK_IDX);

    sal_state_e state_q, state_d;

    logic wt_n, wb_n, alloc_n, ack_n;

    assign wt_n      = WRITE_THROUGH && req_write;
    assign wb_n      = !WRITE_THROUGH && !hit && !any_invalid && victim_dirty;
    assign alloc_n   = !hit && !wt_n;
    assign ack_n     = hit || wt_n;
    assign upd_dirty = !WRITE_THROUGH && req_valid && req_write && hit;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_REPORT);

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_hit        <= 1'b0;
            rsp_hit_way    <= '0;
            rsp_victim_way <= '0;
            rsp_ack        <= 1'b0;
            rsp_alloc      <= 1'b0;
            rsp_wb_req     <= 1'b0;
            rsp_wb_addr    <= '0;
            rsp_wt_req     <= 1'b0;
            rsp_wt_addr    <= '0;
        end else begin
            rsp_hit        <= hit;
            rsp_hit_way    <= hit ? hit_way : '0;
            rsp_victim_way <= victim_way;
            rsp_ack        <= ack_n;
            rsp_alloc      <= alloc_n;
            rsp_wb_req     <= wb_n;
            rsp_wb_addr    <= {victim_tag, req_set, BANK_BITS};
            rsp_wt_req     <= wt_n;
            rsp_wt_addr    <= {req_tag, req_set, BANK_BITS};
        end
    end
endmodule

// File: rtl/setassoc_lookup.sv
module setassoc_lookup #(
    parameter int NUM_SETS      = 8,
    parameter int NUM_WAYS      = 4,
    parameter int TAG_W         = 8,
    parameter int AGE_W         = 3,
    parameter int BANK_W        = 2,
    parameter int BANK_IDX      = 0,
    parameter bit WRITE_THROUGH = 1'b0,
    parameter int SET_W         = $clog2(NUM_SETS),
    parameter int WAY_W         = $clog2(NUM_WAYS),
    parameter int ADDR_W        = TAG_W + SET_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_hit_way,
    output logic [WAY_W-1:0]  rsp_victim_way,
    output logic              rsp_ack,
    output logic              rsp_alloc,
    output logic              rsp_wb_req,
    output logic [ADDR_W-1:0] rsp_wb_addr,
    output logic              rsp_wt_req,
    output logic [ADDR_W-1:0] rsp_wt_addr
);
    logic [NUM_WAYS-1:0]            rd_valid, rd_dirty;
    logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [NUM_WAYS-1:0][AGE_W-1:0] rd_age, new_age;
    logic                           hit, any_invalid, victim_dirty, upd_dirty;
    logic [WAY_W-1:0]               hit_way, victim_way;
    logic [TAG_W-1:0]               victim_tag;

    sal_set_store #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
        .AGE_W(AGE_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(req_set),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_age(rd_age),
        .upd_en(req_valid), .upd_age(new_age),
        .upd_dirty(upd_dirty), .upd_dirty_way(hit_way),
        .fill_en(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag)
    );

    sal_way_eval #(
        .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
    ) u_eval (
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_age(rd_age),
        .req_tag(req_tag), .hit(hit), .hit_way(hit_way), .new_age(new_age),
        .victim_way(victim_way), .any_invalid(any_invalid),
        .victim_dirty(victim_dirty), .victim_tag(victim_tag)
    );

    sal_ctrl #(
        .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W), .BANK_W(BANK_W),
        .BANK_IDX(BANK_IDX), .WRITE_THROUGH(WRITE_THROUGH), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_set(req_set), .req_tag(req_tag), .hit(hit), .hit_way(hit_way),
        .victim_way(victim_way), .any_invalid(any_invalid),
        .victim_dirty(victim_dirty), .victim_tag(victim_tag),
        .upd_dirty(upd_dirty), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_hit_way(rsp_hit_way), .rsp_victim_way(rsp_victim_way),
        .rsp_ack(rsp_ack), .rsp_alloc(rsp_alloc), .rsp_wb_req(rsp_wb_req),
        .rsp_wb_addr(rsp_wb_addr), .rsp_wt_req(rsp_wt_req), .rsp_wt_addr(rsp_wt_addr)
    );
endmodule

// File: rtl/sal_checker.sv
module sal_checker #(
    parameter bit WRITE_THROUGH = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_write,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_ack,
    input logic rsp_alloc,
    input logic rsp_wb_req,
    input logic rsp_wt_req
);
    assert_result_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_result_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_ack && !rsp_alloc && !rsp_wb_req && !rsp_wt_req);

    assert_hit_no_alloc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_ack && !rsp_alloc && !rsp_wb_req));

    assert_ack_alloc_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ack && rsp_alloc));

    assert_miss_ack_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ack == (WRITE_THROUGH && $past(req_write))));

    assert_wt_no_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_THROUGH && rsp_valid) |-> !rsp_wb_req);
endmodule

bind setassoc_lookup sal_checker #(.WRITE_THROUGH(WRITE_THROUGH)) u_sal_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ack(rsp_ack),
    .rsp_alloc(rsp_alloc), .rsp_wb_req(rsp_wb_req), .rsp_wt_req(rsp_wt_req)
);

// File: tb/setassoc_lookup_test.sv
`timescale 1ns/1ps
module setassoc_lookup_test;
    localparam int SETS = 4, WAYS = 4, TW = 6, AW = 3, BW = 2, BI = 2;
    localparam int SW = 2, WW = 2, ADW = TW + SW + BW, AMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 0, req_write = 0, fill_valid = 0;
    logic [SW-1:0] req_set = 0, fill_set = 0;
    logic [TW-1:0] req_tag = 0, fill_tag = 0;
    logic [WW-1:0] fill_way = 0;

    logic           o_valid[2], o_hit[2], o_ack[2], o_alloc[2], o_wb[2], o_wt[2];
    logic [WW-1:0]  o_hway[2], o_vic[2];
    logic [ADW-1:0] o_wba[2], o_wta[2];

    setassoc_lookup #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .TAG_W(TW), .AGE_W(AW),
        .BANK_W(BW), .BANK_IDX(BI), .WRITE_THROUGH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_set(req_set), .req_tag(req_tag), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_way(fill_way), .fill_tag(fill_tag), .rsp_valid(o_valid[0]), .rsp_hit(o_hit[0]),
        .rsp_hit_way(o_hway[0]), .rsp_victim_way(o_vic[0]), .rsp_ack(o_ack[0]),
        .rsp_alloc(o_alloc[0]), .rsp_wb_req(o_wb[0]), .rsp_wb_addr(o_wba[0]),
        .rsp_wt_req(o_wt[0]), .rsp_wt_addr(o_wta[0]));

    setassoc_lookup #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .TAG_W(TW), .AGE_W(AW),
        .BANK_W(BW), .BANK_IDX(BI), .WRITE_THROUGH(1'b1)) uut_wt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_set(req_set), .req_tag(req_tag), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_way(fill_way), .fill_tag(fill_tag), .rsp_valid(o_valid[1]), .rsp_hit(o_hit[1]),
        .rsp_hit_way(o_hway[1]), .rsp_victim_way(o_vic[1]), .rsp_ack(o_ack[1]),
        .rsp_alloc(o_alloc[1]), .rsp_wb_req(o_wb[1]), .rsp_wb_addr(o_wba[1]),
        .rsp_wt_req(o_wt[1]), .rsp_wt_addr(o_wta[1]));

    // reference model, index 0 = write-back, 1 = write-through
    bit            mv[2][SETS][WAYS];
    bit            md[2][SETS][WAYS];
    logic [TW-1:0] mt[2][SETS][WAYS];
    int            ma[2][SETS][WAYS];

    bit e_hit[2], e_ack[2], e_alloc[2], e_wb[2], e_wt[2], e_inv[2];
    int e_hway[2], e_vic[2], e_wba[2], e_wta[2];

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(string rq, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic model_step(int m, bit rv, int rs, int rt, bit rw,
                              bit fv, int fs, int fw, int ft);
        int nage[WAYS];
        int best;
        if (rv) begin
            e_hit[m] = 0; e_hway[m] = 0; e_inv[m] = 0;
            for (int w = WAYS - 1; w >= 0; w--)
                if (mv[m][rs][w] && mt[m][rs][w] == rt[TW-1:0]) begin e_hit[m] = 1; e_hway[m] = w; end
            for (int w = 0; w < WAYS; w++) begin
                if (mv[m][rs][w] && mt[m][rs][w] == rt[TW-1:0]) nage[w] = 0;
                else if (mv[m][rs][w]) nage[w] = (ma[m][rs][w] == AMAX) ? AMAX : ma[m][rs][w] + 1;
                else nage[w] = ma[m][rs][w];
            end
            e_vic[m] = 0; best = nage[0];
            for (int w = 1; w < WAYS; w++) if (nage[w] > best) begin best = nage[w]; e_vic[m] = w; end
            for (int w = 0; w < WAYS; w++) if (!mv[m][rs][w]) begin e_vic[m] = w; e_inv[m] = 1; end
            e_wt[m]    = (m == 1) && rw;
            e_wb[m]    = (m == 0) && !e_hit[m] && !e_inv[m] && md[m][rs][e_vic[m]];
            e_alloc[m] = !e_hit[m] && !e_wt[m];
            e_ack[m]   = e_hit[m] || e_wt[m];
            e_wba[m]   = (int'(mt[m][rs][e_vic[m]]) << (SW + BW)) | (rs << BW) | BI;
            e_wta[m]   = (rt << (SW + BW)) | (rs << BW) | BI;
            for (int w = 0; w < WAYS; w++) ma[m][rs][w] = nage[w];
            if (m == 0 && rw && e_hit[m]) md[m][rs][e_hway[m]] = 1;
        end
        if (fv) begin
            mv[m][fs][fw] = 1; md[m][fs][fw] = 0; mt[m][fs][fw] = ft[TW-1:0]; ma[m][fs][fw] = 0;
        end
    endtask

    task automatic apply(bit rv, int rs, int rt, bit rw, bit fv, int fs, int fw, int ft);
        @(negedge clk);
        for (int m = 0; m < 2; m++) check("R2 idle rsp_valid", o_valid[m], 0);
        req_valid = rv; req_set = rs[SW-1:0]; req_tag = rt[TW-1:0]; req_write = rw;
        fill_valid = fv; fill_set = fs[SW-1:0]; fill_way = fw[WW-1:0]; fill_tag = ft[TW-1:0];
        for (int m = 0; m < 2; m++) model_step(m, rv, rs, rt, rw, fv, fs, fw, ft);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check("R2 rsp_valid", o_valid[m], rv);
            if (rv) begin
                check("R3 hit", o_hit[m], e_hit[m]);
                check("R3 hit way", o_hway[m], e_hway[m]);
                check(e_inv[m] ? "R6 victim" : "R4/R5 victim", o_vic[m], e_vic[m]);
                check("R7/R8 writeback", o_wb[m], e_wb[m]);
                if (e_wb[m]) check("R8 wb addr", o_wba[m], e_wba[m]);
                check("R9/R10 write forward", o_wt[m], e_wt[m]);
                if (e_wt[m]) check("R9 wt addr", o_wta[m], e_wta[m]);
                check("R11 alloc", o_alloc[m], e_alloc[m]);
                check("R10/R11 ack", o_ack[m], e_ack[m]);
            end
        end
        req_valid = 0; fill_valid = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 rsp_valid after reset", o_valid[0], 0);
        // R1: empty bank misses, victim is highest invalid way (R6)
        apply(1, 1, 5, 0, 0, 0, 0, 0);
        check("R1 empty miss", o_hit[0], 0);
        check("R6 empty victim", o_vic[0], WAYS - 1);
        // fill set 0 with tags 1..4
        for (int w = 0; w < WAYS; w++) apply(0, 0, 0, 0, 1, 0, w, w + 1);
        apply(1, 0, 4, 0, 0, 0, 0, 0);
        check("R12 fill then hit", o_hway[0], 3);
        // saturate ages of ways 1..3
        for (int i = 0; i < 10; i++) apply(1, 0, 1, 0, 0, 0, 0, 0);
        apply(1, 0, 9, 0, 0, 0, 0, 0);
        check("R4 saturation tie to lowest", o_vic[0], 1);
        // dirty way 1 then evict it
        apply(1, 0, 2, 1, 0, 0, 0, 0);
        check("R9 wt on write hit", o_wt[1], 1);
        for (int i = 0; i < 8; i++) apply(1, 0, 1, 0, 0, 0, 0, 0);
        apply(1, 0, 9, 0, 0, 0, 0, 0);
        check("R7 dirty victim wb", o_wb[0], 1);
        check("R9 no wb in wt mode", o_wb[1], 0);
        check("R8 wb address", o_wba[0], (2 << 4) | BI);
        // write miss: WT acks without alloc, WB allocates
        apply(1, 0, 30, 1, 0, 0, 0, 0);
        check("R10 wt write miss ack", o_ack[1], 1);
        check("R11 wb write miss alloc", o_alloc[0], 1);
        // fill collides with lookup on the same way
        apply(1, 0, 1, 1, 1, 0, 0, 20);
        apply(1, 0, 20, 0, 0, 0, 0, 0);
        check("R12 fill wins hit", o_hit[0], 1);
        apply(1, 0, 1, 0, 0, 0, 0, 0);
        check("R12 old tag gone", o_hit[0], 0);
        // random phase
        for (int i = 0; i < 1500; i++) begin
            apply(($urandom % 4) != 0, $urandom % SETS, $urandom % 8, $urandom % 2,
                  ($urandom % 5) < 2, $urandom % SETS, $urandom % WAYS, $urandom % 8);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule